// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Controller

This block sits on the active-low chip-enable line between a processor and a memory device. While the supervisor's reset is inactive, it passes the processor's chip-enable straight through to the memory. While reset is active, it holds the memory deselected, so a processor with a collapsing supply cannot write corrupt data.

When reset arrives in the middle of an access, the gate is not closed at once. The access already in progress is allowed to finish: the gate closes when the incoming chip-enable returns high. If the access is still running after a bounded number of clock cycles, the gate closes anyway. The bound is the parameter `TIMEOUT_CYC`; its default of 3000 cycles is 15 µs at a 200 MHz clock.

After power-on, the gate stays closed until the supervisor releases reset. It then opens only at an instant when the incoming chip-enable is high, so the memory never sees a shortened select pulse.

Top module: `ce_reset_gate`

## Requirements
- R1: While `porN` is low, and after it rises until the first reopening, `gateOpen` is 0 and `ceOutN` is 1.
- R2: While `gateOpen` is 1, `ceOutN` equals `ceInN` in the same cycle, with no register in the path.
- R3: While `gateOpen` is 0, `ceOutN` is 1, whatever the value of `ceInN`.
- R4: At a clock edge where the gate is open, not draining, `supReset` is 1 and `ceInN` is 1, the gate closes, so `gateOpen` is 0 after that edge.
- R5: Reset may be first seen with `ceInN` low. The gate then stays open while `ceInN` stays low, up to the limit in R6. It closes at the first later edge that samples `ceInN` high.
- R6: Reset may be first seen at edge E0 with `ceInN` low, and `ceInN` may stay low with `supReset` still 1. The gate then stays open through edge E(TIMEOUT_CYC−1) and closes at edge E(TIMEOUT_CYC).
- R7: While the gate is closed and `supReset` is 1, it stays closed, whatever `ceInN` does.
- R8: A closed gate reopens only at an edge that samples `supReset` at 0 and `ceInN` at 1. An edge that samples `ceInN` low keeps it closed.
- R9: If `supReset` returns to 0 while an access is draining, the gate returns to the normal open state. A later `ceInN` low of any length then never closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timeout count and the state |
| porN | input | 1 | Asynchronous power-on reset, active low; puts the gate in the closed state |
| supReset | input | 1 | Reset from the supply supervisor, active high |
| ceInN | input | 1 | Chip-enable from the processor, active low |
| ceOutN | output | 1 | Chip-enable to the memory, active low; forced high while the gate is closed |
| gateOpen | output | 1 | 1 while the gate passes `ceInN` through to `ceOutN` |

## Verification
The gate is driven with several chip-enable patterns, and each one tells apart a different closing behaviour. In the first, reset arrives while chip-enable is idle high, which separates an immediate close from a deferred one. In the second, reset arrives during an access that ends early, which shows that the close waits for chip-enable to rise. In the third, the access is held low until the timeout, which pins the exact cycle at which a forced close happens. Further patterns toggle chip-enable while reset is held, release reset with chip-enable low, and drop reset during a drain followed by a long access; these separate a correct reopening from a premature one and from a spurious timeout.

// File: rtl/cegate_pkg.sv
package cegate_pkg;

  typedef enum logic [1:0] {
    GATE_OPEN  = 2'd0,
    GATE_DRAIN = 2'd1,
    GATE_SHUT  = 2'd2
  } gateState_e;

  typedef struct packed {
    logic cntLoad;
    logic cntInc;
    logic passEn;
  } gateStrobe_t;

endpackage

// File: rtl/cegate_dp.sv
module cegate_dp
  import cegate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3000
) (
  input  logic        clk,
  input  logic        porN,
  input  gateStrobe_t strobe,
  input  logic        ceInN,
  output logic        ceOutN,
  output logic        cntDone
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(TIMEOUT_CYC);

  logic [CNT_W-1:0] drainCnt;

  // The edge that first sees reset counts as cycle one of the drain window.
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      drainCnt <= '0;
    end else if (strobe.cntLoad) begin
      drainCnt <= CNT_W'(1);
    end else if (strobe.cntInc && (drainCnt != CNT_LIMIT)) begin
      drainCnt <= drainCnt + CNT_W'(1);
    end
  end

  assign cntDone = (drainCnt >= CNT_LIMIT);

  // A closed gate drives the memory select to its inactive level.
  assign ceOutN = strobe.passEn ? ceInN : 1'b1;

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!porN)
    drainCnt <= CNT_LIMIT);

endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl
  import cegate_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        supReset,
  input  logic        ceInN,
  input  logic        cntDone,
  output gateStrobe_t strobe,
  output logic        gateOpen
);

  gateState_e state, stateNxt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= GATE_SHUT;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt       = state;
    strobe.cntLoad = 1'b0;
    strobe.cntInc  = 1'b0;
    unique case (state)
      GATE_OPEN: begin
        if (supReset) begin
          if (ceInN) begin
            stateNxt = GATE_SHUT;
          end else begin
            stateNxt       = GATE_DRAIN;
            strobe.cntLoad = 1'b1;
          end
        end
      end
      GATE_DRAIN: begin
        if (!supReset) begin
          stateNxt = GATE_OPEN;
        end else if (ceInN || cntDone) begin
          stateNxt = GATE_SHUT;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      GATE_SHUT: begin
        if (!supReset && ceInN) stateNxt = GATE_OPEN;
      end
      default: stateNxt = GATE_SHUT;
    endcase
  end

  assign strobe.passEn = (state != GATE_SHUT);
  assign gateOpen      = strobe.passEn;

  p_idle_close_r4: assert property (@(posedge clk) disable iff (!porN)
    (state == GATE_OPEN && supReset && ceInN) |=> !gateOpen);

  p_drain_keep_r5: assert property (@(posedge clk) disable iff (!porN)
    (state == GATE_DRAIN && supReset && !ceInN && !cntDone) |=> gateOpen);

  p_timeout_r6: assert property (@(posedge clk) disable iff (!porN)
    (state == GATE_DRAIN && supReset && cntDone) |=> !gateOpen);

  p_hold_shut_r7: assert property (@(posedge clk) disable iff (!porN)
    (!gateOpen && supReset) |=> !gateOpen);

  p_no_partial_r8: assert property (@(posedge clk) disable iff (!porN)
    (!gateOpen && !ceInN) |=> !gateOpen);

  p_release_r9: assert property (@(posedge clk) disable iff (!porN)
    (state == GATE_DRAIN && !supReset) |=> (state == GATE_OPEN));

endmodule

// File: rtl/ce_reset_gate.sv
module ce_reset_gate
  import cegate_pkg::*;
#(
  parameter int TIMEOUT_CYC = 3000
) (
  input  logic clk,
  input  logic porN,
  input  logic supReset,
  input  logic ceInN,
  output logic ceOutN,
  output logic gateOpen
);

  gateStrobe_t strobe;
  logic        cntDone;

  cegate_ctrl ctrl_i (
    .clk      (clk),
    .porN     (porN),
    .supReset (supReset),
    .ceInN    (ceInN),
    .cntDone  (cntDone),
    .strobe   (strobe),
    .gateOpen (gateOpen)
  );

  cegate_dp #(.TIMEOUT_CYC(TIMEOUT_CYC)) dp_i (
    .clk     (clk),
    .porN    (porN),
    .strobe  (strobe),
    .ceInN   (ceInN),
    .ceOutN  (ceOutN),
    .cntDone (cntDone)
  );

  p_pass_r2: assert property (@(posedge clk) disable iff (!porN)
    gateOpen |-> (ceOutN == ceInN));

  p_shut_high_r3: assert property (@(posedge clk) disable iff (!porN)
    !gateOpen |-> ceOutN);

endmodule

// File: tb/ce_reset_gate_tb_top.sv
module ce_reset_gate_tb_top;

  localparam int T = 8;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supReset = 1'b1;
  logic ceInN = 1'b1;
  logic ceOutN, gateOpen;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic  expOpen;
    logic  expCe;
    string tag;
  } expItem_t;

  expItem_t sbQ[$];

  always #2.5 clk = ~clk;

  ce_reset_gate #(.TIMEOUT_CYC(T)) dut_i (
    .clk      (clk),
    .porN     (porN),
    .supReset (supReset),
    .ceInN    (ceInN),
    .ceOutN   (ceOutN),
    .gateOpen (gateOpen)
  );

  task automatic check(input logic actO, input logic actC,
                       input logic expO, input logic expC, input string tag);
    total++;
    if (actO !== expO || actC !== expC) begin
      bad++;
      $display("FAIL %s gateOpen=%0b exp=%0b ceOutN=%0b exp=%0b",
               tag, actO, expO, actC, expC);
    end
  endtask

  // Driver: applies inputs for one cycle and records the expected outputs.
  task automatic step(input logic sup, input logic ce,
                      input logic expO, input string tag);
    expItem_t it;
    @(negedge clk);
    supReset = sup;
    ceInN    = ce;
    it.expOpen = expO;
    it.expCe   = expO ? ce : 1'b1;
    it.tag     = tag;
    sbQ.push_back(it);
  endtask

  // Monitor: compares outputs with the scoreboard, away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        check(gateOpen, ceOutN, it.expOpen, it.expCe, it.tag);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: held in power-on reset, the gate is closed even with ceInN low
    repeat (2) @(negedge clk);
    check(gateOpen, ceOutN, 1'b0, 1'b1, "R1 por");
    ceInN = 1'b0;
    #1;
    check(gateOpen, ceOutN, 1'b0, 1'b1, "R1 por ce low");
    @(negedge clk);
    porN = 1'b1;

    // R1 and R7: supervisor still in reset, ceInN toggling
    step(1, 1, 0, "R1");
    step(1, 0, 0, "R7");
    step(1, 1, 0, "R7");
    step(1, 0, 0, "R7");
    // R8: released with ceInN low, so the gate stays closed
    step(0, 0, 0, "R8");
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R8");
    // R2: open, pass-through
    step(0, 0, 1, "R2");
    step(0, 1, 1, "R2");
    step(0, 0, 1, "R2");
    step(0, 1, 1, "R2");
    // R4: reset with ceInN idle closes at once
    step(1, 1, 1, "R4");
    step(1, 0, 0, "R3");
    step(1, 1, 0, "R3");
    step(0, 1, 0, "R8");
    step(0, 0, 1, "R2");
    // R5: reset during an access that ends early
    step(1, 0, 1, "R5");
    step(1, 0, 1, "R5");
    step(1, 0, 1, "R5");
    step(1, 1, 1, "R5");
    step(1, 0, 0, "R5");
    // reopen
    step(0, 1, 0, "R8");
    step(0, 0, 1, "R2");
    // R6: access held until the timeout
    step(1, 0, 1, "R6");
    for (int i = 1; i <= T; i++) step(1, 0, 1, "R6");
    step(1, 0, 0, "R6");
    step(1, 0, 0, "R6");
    // R9: reset drops during a drain
    step(0, 0, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 0, 1, "R2");
    step(1, 0, 1, "R9");
    step(1, 0, 1, "R9");
    step(0, 0, 1, "R9");
    for (int i = 0; i < T + 4; i++) step(0, 0, 1, "R9");
    step(0, 1, 1, "R9");
    step(0, 0, 1, "R9");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule